// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block runs inside a coprocessor that sits beside a host processor. The host prefetches instruction bytes into its own queue, and the coprocessor cannot see that queue. The tracker keeps a copy of it. It snoops the host's code-fetch bus cycles and takes each byte from the data phase of the cycle. It then follows the host's two-bit queue status code to pop the head byte, flush every entry, or leave the copy alone.

Popped bytes are grouped into instructions. When an opcode of the escape class reaches the head as the first byte of an instruction, the tracker holds it and waits for the next byte, which is the operand-format (ModRM) byte. When that byte is popped, the pair is dispatched to a stub execution stage. `busy` then stays high for a programmable number of cycles so the host knows the coprocessor is working. Every other opcode is popped and discarded. Queue overrun and underrun are recorded in sticky error flags.

Top module: `coproc_queue_mirror`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue (`queueLevel` = 0), clears `busy`, `dispValid`, `dispOpcode`, `dispModrm` and both error flags, and discards any pending escape opcode.
- R2: A byte is captured only in the clock after a cycle start (`cycStart` = 1) that had `codeFetch` = 1. The value on `busAd` in that second clock is the one stored. The address-phase value is never stored, and cycles started with `codeFetch` = 0 store nothing.
- R3: Queue status 2'b00 leaves the queue contents and `queueLevel` unchanged.
- R4: Queue status 2'b01 or 2'b11 removes the head byte, so `queueLevel` drops by one unless a capture lands in the same clock. Bytes leave in the order they were captured.
- R5: Queue status 2'b10 empties the queue on that edge. A capture in the same clock is dropped without raising an error. A pending escape opcode is discarded, so a later 2'b11 pop dispatches nothing.
- R6: A byte popped with status 2'b01 is an escape opcode when bits [7:3] equal 5'b11011. Any other opcode, and the byte that follows it, is discarded with no dispatch.
- R7: A byte popped with status 2'b11 while an escape opcode is pending causes a dispatch. `dispValid` is high for exactly one cycle after that edge, with `dispOpcode` holding the escape opcode and `dispModrm` holding the popped byte. Both values are kept until the next dispatch.
- R8: `busy` rises on the dispatch edge and stays high for `execCycles` cycles. A value of 0 counts as 1.
- R9: A capture that arrives while the queue holds 6 bytes is dropped and sets the sticky `overflowErr`.
- R10: A pop (status 2'b01 or 2'b11) on an empty queue changes nothing in the queue and sets the sticky `underflowErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycStart | input | 1 | High in the address clock of a host bus cycle |
| codeFetch | input | 1 | Sampled with `cycStart`; marks the cycle as an instruction fetch |
| busAd | input | 8 | Multiplexed address/data bus; fetched byte in the clock after `cycStart` |
| queueStat | input | 2 | Host queue status: 00 idle, 01 first byte, 10 flush, 11 next byte |
| execCycles | input | 8 | Length of the busy window after a dispatch |
| busy | output | 1 | High while the stub execution stage runs |
| dispValid | output | 1 | One-cycle dispatch strobe |
| dispOpcode | output | 8 | Escape opcode of the last dispatch |
| dispModrm | output | 8 | Byte that followed the escape opcode |
| queueLevel | output | 3 | Number of bytes held in the mirror queue |
| overflowErr | output | 1 | Sticky: a capture was dropped because the queue was full |
| underflowErr | output | 1 | Sticky: a pop arrived while the queue was empty |

## Verification
A wrong pointer or count in the queue shows up on `queueLevel` on the next clock. A wrong read order stays hidden until the misplaced byte reaches the head and is popped. It then shows as a wrong `dispOpcode` or `dispModrm`, or as a dispatch that should not happen. A fault in the pending-escape state shows only at the second pop of an instruction, through `dispValid` and `busy`. For that reason the tests pop whole instructions across flushes and full queues instead of only watching the level.

// File: rtl/cqm_pkg.sv
package cqm_pkg;

  // Host queue status encodings
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qStat_t;

  // Upper five bits shared by all escape-class opcodes
  localparam logic [4:0] ESC_PREFIX = 5'b11011;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic latchOp;
    logic latchModrm;
  } cqmStrobe_t;

endpackage

// File: rtl/cqm_datapath.sv
module cqm_datapath
  import cqm_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  cqmStrobe_t                     str,
  input  logic [DATA_W-1:0]              busData,
  output logic                           headIsEsc,
  output logic                           qFull,
  output logic                           qEmpty,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic [DATA_W-1:0]              dispOp,
  output logic [DATA_W-1:0]              dispModrm
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] entry [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [DATA_W-1:0] headByte, pendOp;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // One write-enabled register per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (str.push && wrPtr == PTR_W'(i)) entry[i] <= busData;
    end
  end

  assign headByte  = entry[rdPtr];
  assign headIsEsc = (headByte[DATA_W-1 -: 5] == ESC_PREFIX);
  assign qFull     = (level == CNT_W'(DEPTH));
  assign qEmpty    = (level == '0);

  always_ff @(posedge clk) begin
    if (rst || str.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (str.push) wrPtr <= ptrInc(wrPtr);
      if (str.pop)  rdPtr <= ptrInc(rdPtr);
      unique case ({str.push, str.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendOp    <= '0;
      dispOp    <= '0;
      dispModrm <= '0;
    end else begin
      if (str.latchOp) pendOp <= headByte;
      if (str.latchModrm) begin
        dispOp    <= pendOp;
        dispModrm <= headByte;
      end
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    str.flush |=> (level == '0));

  // R4
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (str.pop && !str.push && !str.flush) |=> (level == CNT_W'($past(level) - 1'b1)));

endmodule

// File: rtl/cqm_control.sv
module cqm_control
  import cqm_pkg::*;
#(
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       queueStat,
  input  logic             cycStart,
  input  logic             codeFetch,
  input  logic [CYC_W-1:0] execCycles,
  input  logic             qFull,
  input  logic             qEmpty,
  input  logic             headIsEsc,
  output cqmStrobe_t       str,
  output logic             busy,
  output logic             dispValid,
  output logic             overflowErr,
  output logic             underflowErr
);

  qStat_t           qs;
  logic             fetchPend, awaitModrm, popReq, dataPhase;
  logic [CYC_W-1:0] busyCnt;

  assign qs        = qStat_t'(queueStat);
  assign popReq    = (qs == QS_FIRST) || (qs == QS_NEXT);
  assign dataPhase = fetchPend && (qs != QS_FLUSH);

  always_comb begin
    str            = '0;
    str.flush      = (qs == QS_FLUSH);
    str.pop        = popReq && !qEmpty;
    str.push       = dataPhase && !qFull;
    str.latchOp    = str.pop && (qs == QS_FIRST) && headIsEsc;
    str.latchModrm = str.pop && (qs == QS_NEXT) && awaitModrm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchPend    <= 1'b0;
      awaitModrm   <= 1'b0;
      busyCnt      <= '0;
      dispValid    <= 1'b0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      fetchPend <= cycStart && codeFetch;
      dispValid <= str.latchModrm;
      if (dataPhase && qFull) overflowErr  <= 1'b1;
      if (popReq && qEmpty)   underflowErr <= 1'b1;
      if (str.flush || str.latchModrm)               awaitModrm <= 1'b0;
      else if (str.pop && qs == QS_FIRST)            awaitModrm <= headIsEsc;
      if (str.latchModrm)
        busyCnt <= (execCycles == '0) ? CYC_W'(1) : execCycles;
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  // R10
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflowErr |=> underflowErr);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);

  // R7
  disp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dispValid |=> !dispValid);

  // R8
  disp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dispValid |-> busy);

  // R5
  flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    str.flush |-> !(str.push || str.pop || str.latchModrm));

endmodule

// File: rtl/coproc_queue_mirror.sv
module coproc_queue_mirror
  import cqm_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cycStart,
  input  logic                       codeFetch,
  input  logic [DATA_W-1:0]          busAd,
  input  logic [1:0]                 queueStat,
  input  logic [CYC_W-1:0]           execCycles,
  output logic                       busy,
  output logic                       dispValid,
  output logic [DATA_W-1:0]          dispOpcode,
  output logic [DATA_W-1:0]          dispModrm,
  output logic [$clog2(DEPTH+1)-1:0] queueLevel,
  output logic                       overflowErr,
  output logic                       underflowErr
);

  cqmStrobe_t str;
  logic       qFull, qEmpty, headIsEsc;

  cqm_control #(.CYC_W(CYC_W)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .queueStat    (queueStat),
    .cycStart     (cycStart),
    .codeFetch    (codeFetch),
    .execCycles   (execCycles),
    .qFull        (qFull),
    .qEmpty       (qEmpty),
    .headIsEsc    (headIsEsc),
    .str          (str),
    .busy         (busy),
    .dispValid    (dispValid),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  cqm_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .str       (str),
    .busData   (busAd),
    .headIsEsc (headIsEsc),
    .qFull     (qFull),
    .qEmpty    (qEmpty),
    .level     (queueLevel),
    .dispOp    (dispOpcode),
    .dispModrm (dispModrm)
  );

endmodule

// File: tb/test_coproc_queue_mirror.sv
`timescale 1ns/100ps
module test_coproc_queue_mirror;

  logic       clk = 1'b0;
  logic       rst;
  logic       cycStart, codeFetch;
  logic [7:0] busAd;
  logic [1:0] queueStat;
  logic [7:0] execCycles;
  logic       busy, dispValid, overflowErr, underflowErr;
  logic [7:0] dispOpcode, dispModrm;
  logic [2:0] queueLevel;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  coproc_queue_mirror i_coproc_queue_mirror (
    .clk(clk), .rst(rst), .cycStart(cycStart), .codeFetch(codeFetch),
    .busAd(busAd), .queueStat(queueStat), .execCycles(execCycles),
    .busy(busy), .dispValid(dispValid), .dispOpcode(dispOpcode),
    .dispModrm(dispModrm), .queueLevel(queueLevel),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  // {cycStart, codeFetch, busAd, queueStat, expLevel, expDispValid, expBusy}
  localparam int NV = 31;
  localparam logic [16:0] VECS [NV] = '{
    {1'b1,1'b1,8'hAA,2'b00,3'd0,1'b0,1'b0}, // R2 address phase
    {1'b0,1'b0,8'hD8,2'b00,3'd1,1'b0,1'b0}, // R2 data phase captured
    {1'b1,1'b1,8'h11,2'b00,3'd1,1'b0,1'b0},
    {1'b0,1'b0,8'hC0,2'b00,3'd2,1'b0,1'b0},
    {1'b1,1'b0,8'h22,2'b00,3'd2,1'b0,1'b0}, // R2 non-fetch cycle
    {1'b0,1'b0,8'h33,2'b00,3'd2,1'b0,1'b0},
    {1'b0,1'b0,8'h00,2'b01,3'd1,1'b0,1'b0}, // R6 escape popped
    {1'b0,1'b0,8'h00,2'b00,3'd1,1'b0,1'b0}, // R3 idle
    {1'b0,1'b0,8'h00,2'b11,3'd0,1'b1,1'b1}, // R7 dispatch
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b1}, // R8
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b1},
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b0},
    {1'b1,1'b1,8'h44,2'b00,3'd0,1'b0,1'b0},
    {1'b0,1'b0,8'h90,2'b00,3'd1,1'b0,1'b0},
    {1'b1,1'b1,8'h00,2'b00,3'd1,1'b0,1'b0},
    {1'b0,1'b0,8'h05,2'b00,3'd2,1'b0,1'b0},
    {1'b0,1'b0,8'h00,2'b01,3'd1,1'b0,1'b0}, // R6 non-escape
    {1'b0,1'b0,8'h00,2'b11,3'd0,1'b0,1'b0}, // R6 no dispatch
    {1'b1,1'b1,8'h00,2'b00,3'd0,1'b0,1'b0},
    {1'b0,1'b0,8'hDF,2'b00,3'd1,1'b0,1'b0},
    {1'b1,1'b1,8'h00,2'b00,3'd1,1'b0,1'b0},
    {1'b0,1'b0,8'h12,2'b01,3'd1,1'b0,1'b0}, // R4 pop and push together
    {1'b0,1'b0,8'h00,2'b11,3'd0,1'b1,1'b1}, // R7
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b1},
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b1},
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b0},
    {1'b1,1'b1,8'h00,2'b00,3'd0,1'b0,1'b0},
    {1'b0,1'b0,8'h01,2'b00,3'd1,1'b0,1'b0},
    {1'b1,1'b1,8'h00,2'b00,3'd1,1'b0,1'b0},
    {1'b0,1'b0,8'h02,2'b10,3'd0,1'b0,1'b0}, // R5 flush beats capture
    {1'b0,1'b0,8'h00,2'b00,3'd0,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cs, input logic cf, input logic [7:0] b, input logic [1:0] q);
    cycStart = cs; codeFetch = cf; busAd = b; queueStat = q;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetchByte(input logic [7:0] b);
    step(1'b1, 1'b1, 8'hEE, 2'b00);
    step(1'b0, 1'b0, b, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; execCycles = 8'd3;
    cycStart = 1'b0; codeFetch = 1'b0; busAd = 8'h00; queueStat = 2'b00;
    @(negedge clk);
    step(1'b0, 1'b0, 8'h00, 2'b00);
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", 8'(queueLevel), 8'd0);
    chk("R1 busy", 8'(busy), 8'd0);
    chk("R1 dispValid", 8'(dispValid), 8'd0);
    chk("R1 flags", 8'({overflowErr, underflowErr}), 8'd0);
    chk("R1 dispOpcode", dispOpcode, 8'h00);

    // Table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VECS[i];
      step(v[16], v[15], v[14:7], v[6:5]);
      chk("R4 level", 8'(queueLevel), 8'(v[4:2]));
      chk("R7 dispValid", 8'(dispValid), 8'(v[1]));
      chk("R8 busy", 8'(busy), 8'(v[0]));
    end
    chk("R7 dispOpcode", dispOpcode, 8'hDF);
    chk("R7 dispModrm", dispModrm, 8'h12);
    chk("R9 no overflow yet", 8'(overflowErr), 8'd0);

    // R10 underflow on empty pop, sticky
    step(1'b0, 1'b0, 8'h00, 2'b01);
    chk("R10 underflow set", 8'(underflowErr), 8'd1);
    chk("R10 level unchanged", 8'(queueLevel), 8'd0);
    step(1'b0, 1'b0, 8'h00, 2'b00);
    chk("R10 underflow sticky", 8'(underflowErr), 8'd1);

    // R9 overflow and R11-style ordering through dispatch
    fetchByte(8'h10); fetchByte(8'h20); fetchByte(8'h30);
    fetchByte(8'h40); fetchByte(8'hD9); fetchByte(8'h5A);
    chk("R9 level full", 8'(queueLevel), 8'd6);
    chk("R9 no overflow at six", 8'(overflowErr), 8'd0);
    fetchByte(8'h77);
    chk("R9 dropped", 8'(queueLevel), 8'd6);
    chk("R9 overflow set", 8'(overflowErr), 8'd1);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 8'h00, 2'b11);
    chk("R4 level after pops", 8'(queueLevel), 8'd2);
    chk("R6 no dispatch on plain bytes", 8'(busy), 8'd0);
    step(1'b0, 1'b0, 8'h00, 2'b01);
    step(1'b0, 1'b0, 8'h00, 2'b11);
    chk("R4 order dispValid", 8'(dispValid), 8'd1);
    chk("R4 order opcode", dispOpcode, 8'hD9);
    chk("R9 order modrm", dispModrm, 8'h5A);
    chk("R9 empty after", 8'(queueLevel), 8'd0);
    repeat (3) step(1'b0, 1'b0, 8'h00, 2'b00);

    // R5 flush discards pending escape
    fetchByte(8'hDC); fetchByte(8'h3C);
    step(1'b0, 1'b0, 8'h00, 2'b01);
    step(1'b0, 1'b0, 8'h00, 2'b10);
    chk("R5 flushed", 8'(queueLevel), 8'd0);
    fetchByte(8'h55);
    step(1'b0, 1'b0, 8'h00, 2'b11);
    chk("R5 no dispatch after flush", 8'(dispValid), 8'd0);
    chk("R5 busy stays low", 8'(busy), 8'd0);
    chk("R5 modrm kept", dispModrm, 8'h5A);

    // R8 execCycles of zero gives a single busy cycle
    execCycles = 8'd0;
    fetchByte(8'hDD); fetchByte(8'h41);
    step(1'b0, 1'b0, 8'h00, 2'b01);
    step(1'b0, 1'b0, 8'h00, 2'b11);
    chk("R8 busy one", 8'(busy), 8'd1);
    step(1'b0, 1'b0, 8'h00, 2'b00);
    chk("R8 busy drops", 8'(busy), 8'd0);

    // R1 reset mid-operation clears sticky state
    execCycles = 8'd9;
    fetchByte(8'hDB); fetchByte(8'h07);
    step(1'b0, 1'b0, 8'h00, 2'b01);
    step(1'b0, 1'b0, 8'h00, 2'b11);
    fetchByte(8'hAB);
    rst = 1'b1;
    step(1'b0, 1'b0, 8'h00, 2'b00);
    rst = 1'b0;
    chk("R1 level cleared", 8'(queueLevel), 8'd0);
    chk("R1 busy cleared", 8'(busy), 8'd0);
    chk("R1 flags cleared", 8'({overflowErr, underflowErr}), 8'd0);
    chk("R1 opcode cleared", dispOpcode, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule